// File: doc/BRIEF.md
# Pseudo-Random Loopback Self-Test Checker

This block is the digital half of a modem's built-in self-test. While the test input is high, the block cuts off the external transmit data and feeds the transmitter a pseudo-random bit stream. The modulated signal is routed back to the receiver by an analog path outside this block. The bits that come back are compared with a copy of the generated stream, held back by the number of bit periods the loop takes.

The generator advances once per bit tick. Each emitted bit also enters a delay line whose depth is a parameter. A comparison is made only on a sync strobe, which marks a recovered-clock instant, and only after the delay line has been filled since entry into test. Any mismatch latches a fail level. While the test is active, that level is driven onto the receive data output, so low means pass and high means fail. With the test input low, the block passes both data paths through unchanged.

Top module: `pn_loopback_bist`

## Requirements
- R1: With `test_en` low, `tx_bit` equals `ext_tx_bit` and `rxd_out` equals `rx_bit` in the same cycle.
- R2: With `test_en` high, `tx_bit` shows bit 6 of the generator state and does not follow `ext_tx_bit`.
- R3: The generator is a 7-bit shift register with next state `{s[5:0], s[6]^s[5]}` (polynomial x^7+x^6+1), starting from the nonzero `SEED`. Its output sequence repeats every 127 bits.
- R4: The generator advances only on a `bit_tick` cycle while in test. It is reloaded with `SEED` whenever `test_en` is low.
- R5: Number the bits shown on `tx_bit` before each tick since entry as b1, b2, and so on. After k ticks, the reference bit is b(k-DELAY_BITS+1).
- R6: A comparison happens only in a cycle with `sync_strobe` high, and only once at least DELAY_BITS ticks have occurred since entry into test. Strobes before that have no effect.
- R7: A strobe whose `rx_bit` differs from the reference drives `rxd_out` high from the next cycle on. A matching strobe leaves `rxd_out` low.
- R8: The fail level is sticky until `test_en` goes low. On entry into test, `rxd_out` starts low.
- R9: When `bit_tick` and `sync_strobe` coincide, the comparison uses the reference as it stood before that tick's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | High selects self-test |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| sync_strobe | input | 1 | One-cycle pulse at a recovered-clock sampling instant |
| rx_bit | input | 1 | Demodulated receive bit |
| ext_tx_bit | input | 1 | External transmit data |
| tx_bit | output | 1 | Data to the modulator |
| rxd_out | output | 1 | Receive data, or the fail level in test |

## Verification
The two events that can land in one cycle are a bit tick, which shifts the delay line, and a sync strobe, which reads the delay line. The bench issues both in the same cycle at a point where the reference bits before and after the shift differ. It first sends the pre-shift reference and expects `rxd_out` to stay low. It then repeats the coincidence with the post-shift value and expects `rxd_out` to go high. A strobe that coincides with the tick that fills the delay line is likewise judged against the arming rule.

// File: rtl/pn_loopback_bist.sv
module pn_loopback_bist #(
  parameter int         DELAY_BITS = 4,
  parameter logic [6:0] SEED       = 7'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic bit_tick,
  input  logic sync_strobe,
  input  logic rx_bit,
  input  logic ext_tx_bit,
  output logic tx_bit,
  output logic rxd_out
);
  localparam int FW = $clog2(DELAY_BITS + 1);

  logic [6:0]            pn_q;
  logic [DELAY_BITS-1:0] dly_q;
  logic [FW-1:0]         fill_q;
  logic                  fail_q;

  wire pn_bit  = pn_q[6];
  wire ref_bit = dly_q[DELAY_BITS-1];
  wire armed   = (fill_q == FW'(DELAY_BITS));
  wire miss    = test_en & sync_strobe & armed & (rx_bit ^ ref_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pn_q   <= SEED;
      dly_q  <= '0;
      fill_q <= '0;
      fail_q <= 1'b0;
    end else if (!test_en) begin
      pn_q   <= SEED;
      dly_q  <= '0;
      fill_q <= '0;
      fail_q <= 1'b0;
    end else begin
      if (bit_tick) begin
        pn_q  <= {pn_q[5:0], pn_q[6] ^ pn_q[5]};
        dly_q <= DELAY_BITS'({dly_q, pn_bit});
        if (!armed) fill_q <= fill_q + 1'b1;
      end
      if (miss) fail_q <= 1'b1;
    end
  end

  assign tx_bit  = test_en ? pn_bit : ext_tx_bit;
  assign rxd_out = test_en ? fail_q : rx_bit;
endmodule

module pn_loopback_bist_chk (
  input logic clk,
  input logic rst_n,
  input logic test_en,
  input logic bit_tick,
  input logic sync_strobe,
  input logic rx_bit,
  input logic ext_tx_bit,
  input logic tx_bit,
  input logic rxd_out
);
  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (rxd_out == rx_bit)); // R1
  AST_PN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && $past(test_en) && !$past(bit_tick)) |-> $stable(tx_bit)); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && $past(test_en) && $past(rxd_out)) |-> rxd_out); // R8
  AST_FAIL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && $past(test_en) && !$past(sync_strobe) && !$past(rxd_out)) |-> !rxd_out); // R7
  AST_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_en) |-> !rxd_out); // R8
endmodule

bind pn_loopback_bist pn_loopback_bist_chk u_chk (.*);

// File: tb/pn_loopback_bist_bench.sv
module pn_loopback_bist_bench;
  localparam int         D    = 4;
  localparam logic [6:0] SEED = 7'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic test_en = 1'b0, bit_tick = 1'b0, sync_strobe = 1'b0;
  logic rx_bit = 1'b0, ext_tx_bit = 1'b0;
  logic tx_bit, rxd_out;

  int n_chk = 0, n_fail = 0;
  logic bseq [1:400];
  int cnt;

  always #4 clk = ~clk;

  pn_loopback_bist #(.DELAY_BITS(D), .SEED(SEED)) u_pn_loopback_bist (.*);

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic tk, input logic st, input logic rb);
    @(negedge clk);
    bit_tick = tk; sync_strobe = st; rx_bit = rb;
    @(negedge clk);
    bit_tick = 1'b0; sync_strobe = 1'b0;
    if (tk) cnt++;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [6:0] s;
    int k;
    s = SEED;
    for (int i = 1; i <= 400; i++) begin
      bseq[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    for (int i = 1; i <= 127; i++) check(bseq[i], bseq[i+127], "R3 period");

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      ext_tx_bit = v[0]; rx_bit = v[1];
      #1;
      check(tx_bit, v[0], "R1 tx passthru");
      check(rxd_out, v[1], "R1 rx passthru");
    end

    @(negedge clk); test_en = 1'b1; cnt = 0;
    @(negedge clk);
    check(rxd_out, 1'b0, "R8 entry low");
    check(tx_bit, bseq[1], "R2 tx from generator");
    ext_tx_bit = ~bseq[1]; #1;
    check(tx_bit, bseq[1], "R2 ext ignored");

    for (int i = 1; i < D; i++) begin
      check(tx_bit, bseq[cnt+1], "R3 sequence");
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, ~bseq[1]);
      check(rxd_out, 1'b0, "R6 strobe before armed ignored");
    end
    // arming tick coincides with a wrong strobe: still unarmed in that cycle
    cyc(1'b1, 1'b1, ~bseq[1]);
    check(rxd_out, 1'b0, "R6 strobe on arming tick ignored");

    while (cnt < 260) begin
      check(tx_bit, bseq[cnt+1], "R3 sequence");
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, bseq[cnt-D+1]);
      check(rxd_out, 1'b0, "R5 aligned reference passes");
    end

    repeat (5) cyc(1'b0, 1'b0, 1'b0);
    check(tx_bit, bseq[cnt+1], "R4 no advance without tick");

    k = cnt;
    while (bseq[k-D+1] == bseq[k-D+2]) begin
      cyc(1'b1, 1'b1, bseq[cnt-D+1]);
      k = cnt;
    end
    cyc(1'b1, 1'b1, bseq[k-D+1]);
    check(rxd_out, 1'b0, "R9 pre-shift reference used");
    k = cnt;
    while (bseq[k-D+1] == bseq[k-D+2]) begin
      cyc(1'b1, 1'b1, bseq[cnt-D+1]);
      k = cnt;
    end
    cyc(1'b1, 1'b1, bseq[k-D+2]);
    check(rxd_out, 1'b1, "R9 post-shift value rejected");

    @(negedge clk); test_en = 1'b0; rx_bit = 1'b0;
    @(negedge clk); test_en = 1'b1; cnt = 0;
    @(negedge clk);
    check(rxd_out, 1'b0, "R8 cleared by exit");
    check(tx_bit, bseq[1], "R4 reload on exit");
    for (int i = 0; i < D; i++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, ~bseq[1]);
    check(rxd_out, 1'b1, "R7 mismatch fails");
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, bseq[cnt-D+1]);
      check(rxd_out, 1'b1, "R8 sticky through matches");
    end
    @(negedge clk); test_en = 1'b0; rx_bit = 1'b0; #1;
    check(rxd_out, 1'b0, "R1 rx passthru after test");
    rx_bit = 1'b1; #1;
    check(rxd_out, 1'b1, "R1 rx passthru after test");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule